// File: doc/BRIEF.md
# Compressed Instruction Fetch Aligner

The aligner sits between an instruction cache and the decode stage of a pipeline that mixes 32-bit instructions with 16-bit compressed ones. Every cache response is one 32-bit word on a 4-byte boundary. Each response carries two branch predictions: one for the halfword at the word address and one for the halfword two bytes above it. The aligner hands decode exactly one instruction per handshake. That instruction is a full 32-bit word, a single compressed halfword, or a 32-bit instruction joined from the upper half of one word and the lower half of the next. Each instruction goes out with its own pc and the prediction that belongs to its first halfword.

A redirect input gives the new target pc. It drops any half-built instruction and picks the halfword at which fetch resumes. When the target is the upper halfword of a word and that halfword opens a 32-bit instruction, the aligner keeps it. It consumes the word without sending anything, then finishes the instruction from the next response. This costs one cycle in which decode receives nothing.

A halfword is compressed when its two lowest bits are not both 1. Both sides use valid/ready handshakes. A cache word is consumed only in the cycle that uses its last piece, so the cache keeps the word on its bus while in_ready is low.

Top module: `fetch_aligner`

## Requirements
- R1: After reset the aligner holds no saved halfword and starts at the lower halfword. With in_valid low, out_valid and in_ready are both low.
- R2: When fetch is at the lower halfword and its bits [1:0] are 2'b11, the whole word is sent in one cycle. The pc is the word address, the prediction is the pc prediction, out_is_c is 0, and in_ready is high in that cycle.
- R3: When the word holds two compressed halfwords, the lower one is sent first. It goes out zero-extended, with the word address, the pc prediction, out_is_c=1 and in_ready low. The upper one follows in the next accepted cycle with the word address + 2, the pc+2 prediction and in_ready high.
- R4: A saved upper halfword is joined with the lower halfword of the next word as {next_lo, saved}. The result carries the saved halfword's pc and the pc+2 prediction of the word it came from. in_ready stays low in that cycle.
- R5: After a redirect whose target has bit 1 set, the lower halfword of the next word is skipped. A compressed upper halfword is sent with the word address + 2 and the pc+2 prediction, and the word is consumed.
- R6: If the upper halfword at which fetch enters has bits [1:0] == 2'b11, that cycle has out_valid low and in_ready high. The halfword is saved for joining by R4.
- R7: After a join, the upper halfword of the same word is treated as an entry at pc+2. It is sent if compressed, or saved with another empty cycle if it opens a 32-bit instruction.
- R8: In a cycle with redir_valid high, out_valid and in_ready are low. A halfword saved earlier is discarded, so the next word is not joined with it.
- R9: While out_valid is high and out_ready is low, in_ready is low and the presented instruction, pc and prediction stay unchanged.
- R10: out_is_c is 1 exactly when the sent instruction's bits [1:0] are not 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect or flush this cycle |
| redir_pc | input | AW-1 | Target pc bits [AW-1:1] |
| in_valid | input | 1 | Cache word valid |
| in_ready | output | 1 | Cache word consumed this cycle |
| in_addr | input | AW-2 | Word address bits [AW-1:2] |
| in_word | input | 32 | Aligned cache word |
| in_pred_lo | input | PW | Prediction for the lower halfword |
| in_pred_hi | input | PW | Prediction for the upper halfword |
| out_valid | output | 1 | Instruction valid toward decode |
| out_ready | input | 1 | Decode accepts |
| out_instr | output | 32 | Instruction, compressed ones zero-extended |
| out_pc | output | AW | Address of the instruction's first halfword |
| out_pred | output | PW | Prediction for the instruction |
| out_is_c | output | 1 | Instruction is compressed |

## Verification
If the halfword position flips wrongly, the port shows it on the next presented word. The wrong half appears with the wrong pc, or a lower compressed half is followed by nothing, so the fault is visible within one handshake. A stale saved halfword shows up only at the next join, as a wrong upper half or a wrong pc/prediction on the joined word. For that reason a flush is followed directly by a full word that would join wrongly if the saved halfword survived. A wrong ready only shows when the next word is lost or repeated, and the cycle-exact in_ready checks catch it in the same cycle.

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int AW = 32,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_valid,
  input  logic [AW-1:1] redir_pc,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:2] in_addr,
  input  logic [31:0]   in_word,
  input  logic [PW-1:0] in_pred_lo,
  input  logic [PW-1:0] in_pred_hi,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_instr,
  output logic [AW-1:0] out_pc,
  output logic [PW-1:0] out_pred,
  output logic          out_is_c
);
  logic          pos_q;
  logic          pend_q;
  logic [15:0]   pend_hw_q;
  logic [AW-1:0] pend_pc_q;
  logic [PW-1:0] pend_pred_q;

  wire [15:0]   lo      = in_word[15:0];
  wire [15:0]   hi      = in_word[31:16];
  wire          lo_c    = lo[1:0] != 2'b11;
  wire          hi_c    = hi[1:0] != 2'b11;
  wire          go      = in_valid & ~redir_valid;
  wire [AW-1:0] pc_lo   = {in_addr, 2'b00};
  wire [AW-1:0] pc_hi   = {in_addr, 2'b10};
  wire          take_hold = go & pos_q & ~pend_q & ~hi_c;
  wire          fire    = out_valid & out_ready;

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_instr = in_word;
    out_pc    = pc_lo;
    out_pred  = in_pred_lo;
    out_is_c  = 1'b0;
    if (pend_q) begin
      out_valid = go;
      out_instr = {lo, pend_hw_q};
      out_pc    = pend_pc_q;
      out_pred  = pend_pred_q;
    end else if (!pos_q) begin
      out_valid = go;
      if (lo_c) begin
        out_instr = {16'h0000, lo};
        out_is_c  = 1'b1;
      end else begin
        in_ready = go & out_ready;
      end
    end else if (hi_c) begin
      out_valid = go;
      in_ready  = go & out_ready;
      out_instr = {16'h0000, hi};
      out_pc    = pc_hi;
      out_pred  = in_pred_hi;
      out_is_c  = 1'b1;
    end else begin
      in_ready = go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_hw_q   <= '0;
      pend_pc_q   <= '0;
      pend_pred_q <= '0;
    end else if (redir_valid) begin
      pend_q <= 1'b0;
      pos_q  <= redir_pc[1];
    end else if (take_hold) begin
      pend_q      <= 1'b1;
      pend_hw_q   <= hi;
      pend_pc_q   <= pc_hi;
      pend_pred_q <= in_pred_hi;
      pos_q       <= 1'b0;
    end else if (fire) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        pos_q  <= 1'b1;
      end else if (!pos_q && lo_c) begin
        pos_q <= 1'b1;
      end else begin
        pos_q <= 1'b0;
      end
    end
  end
endmodule

module fetch_aligner_chk #(
  parameter int AW = 32,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          redir_valid,
  input logic          in_valid,
  input logic          in_ready,
  input logic [31:0]   in_word,
  input logic [PW-1:0] in_pred_lo,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_instr,
  input logic [AW-1:0] out_pc,
  input logic [PW-1:0] out_pred,
  input logic          out_is_c
);
  // R8
  redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!out_valid && !in_ready));

  // R1
  no_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!in_ready && !out_valid));

  // R2
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ready && !out_is_c) |-> (out_instr == in_word && out_pred == in_pred_lo));

  // R9
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redir_valid) ##1 (out_valid && !redir_valid && $stable(in_word))
      |-> ($stable(out_instr) && $stable(out_pc) && $stable(out_pred)));

  // R6
  stall_then_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid && !redir_valid) |=> !(out_valid && out_is_c));

  // R10
  c_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_is_c == (out_instr[1:0] != 2'b11)));

  // R3
  c_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_c) |-> (out_instr[31:16] == 16'h0000));
endmodule

bind fetch_aligner fetch_aligner_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .in_valid(in_valid),
  .in_ready(in_ready), .in_word(in_word), .in_pred_lo(in_pred_lo),
  .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
  .out_pc(out_pc), .out_pred(out_pred), .out_is_c(out_is_c)
);

// File: tb/sim_fetch_aligner.sv
`timescale 1ns/1ps
module sim_fetch_aligner;
  localparam int AW = 32;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          redir_valid = 1'b0;
  logic [AW-1:0] redir_full = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_full = '0;
  logic [31:0]   in_word = '0;
  logic [PW-1:0] in_pred_lo = '0;
  logic [PW-1:0] in_pred_hi = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_instr;
  logic [AW-1:0] out_pc;
  logic [PW-1:0] out_pred;
  logic          out_is_c;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_aligner #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_full[AW-1:1]),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_full[AW-1:2]), .in_word(in_word),
    .in_pred_lo(in_pred_lo), .in_pred_hi(in_pred_hi), .out_valid(out_valid),
    .out_ready(out_ready), .out_instr(out_instr), .out_pc(out_pc), .out_pred(out_pred),
    .out_is_c(out_is_c)
  );

  task automatic put(input logic [AW-1:0] a, input logic [31:0] w,
                     input logic [PW-1:0] plo, input logic [PW-1:0] phi);
    redir_valid = 1'b0; in_valid = 1'b1; in_full = a; in_word = w;
    in_pred_lo = plo; in_pred_hi = phi;
  endtask

  task automatic chk(input string tag, input logic ev, input logic [31:0] ei,
                     input logic [AW-1:0] ep, input logic [PW-1:0] epr,
                     input logic ec, input logic er);
    #1;
    n_chk++;
    if (out_valid !== ev || in_ready !== er ||
        (ev && (out_instr !== ei || out_pc !== ep || out_pred !== epr || out_is_c !== ec))) begin
      n_bad++;
      $display("FAIL %s: got v=%b i=%h pc=%h p=%0d c=%b rdy=%b exp v=%b i=%h pc=%h p=%0d c=%b rdy=%b",
               tag, out_valid, out_instr, out_pc, out_pred, out_is_c, in_ready,
               ev, ei, ep, epr, ec, er);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic redirect(input logic [AW-1:0] pc);
    redir_valid = 1'b1; redir_full = pc; in_valid = 1'b1; in_word = 32'h0000_0093;
    chk("R8 redirect quiet", 1'b0, 0, 0, 0, 0, 1'b0);
    step();
    redir_valid = 1'b0;
  endtask

  task automatic t_reset();
    in_valid = 1'b0;
    chk("R1 reset idle", 1'b0, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_full();
    put(32'h100, 32'h00A0_0093, 2'd1, 2'd2);
    chk("R2 full word", 1'b1, 32'h00A0_0093, 32'h100, 2'd1, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_pair();
    put(32'h104, {16'h4505, 16'h4081}, 2'd1, 2'd2);
    chk("R3 lower compressed", 1'b1, 32'h0000_4081, 32'h104, 2'd1, 1'b1, 1'b0);
    step();
    chk("R3 upper compressed", 1'b1, 32'h0000_4505, 32'h106, 2'd2, 1'b1, 1'b1);
    step();
  endtask

  task automatic t_backpressure();
    put(32'h108, {16'h4515, 16'h4091}, 2'd3, 2'd0);
    out_ready = 1'b0;
    chk("R9 stalled lower", 1'b1, 32'h0000_4091, 32'h108, 2'd3, 1'b1, 1'b0);
    step();
    chk("R9 still lower", 1'b1, 32'h0000_4091, 32'h108, 2'd3, 1'b1, 1'b0);
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk("R9 upper blocked", 1'b1, 32'h0000_4515, 32'h10A, 2'd0, 1'b1, 1'b0);
    step();
    out_ready = 1'b1;
    chk("R9 upper released", 1'b1, 32'h0000_4515, 32'h10A, 2'd0, 1'b1, 1'b1);
    step();
  endtask

  task automatic t_enter_c();
    redirect(32'h112);
    put(32'h110, {16'h8082, 16'hFFFF}, 2'd0, 2'd3);
    chk("R5 upper entry compressed", 1'b1, 32'h0000_8082, 32'h112, 2'd3, 1'b1, 1'b1);
    step();
  endtask

  task automatic t_enter_join();
    redirect(32'h11A);
    put(32'h118, {16'h1797, 16'h0001}, 2'd1, 2'd3);
    chk("R6 entry stall", 1'b0, 0, 0, 0, 0, 1'b1);
    step();
    put(32'h11C, {16'h4505, 16'h0000}, 2'd0, 2'd2);
    chk("R4 joined", 1'b1, 32'h0000_1797, 32'h11A, 2'd3, 1'b0, 1'b0);
    step();
    chk("R7 upper after join", 1'b1, 32'h0000_4505, 32'h11E, 2'd2, 1'b1, 1'b1);
    step();
  endtask

  task automatic t_chain();
    redirect(32'h12A);
    put(32'h128, {16'h0293, 16'h0001}, 2'd0, 2'd1);
    chk("R6 chain stall", 1'b0, 0, 0, 0, 0, 1'b1);
    step();
    put(32'h12C, {16'h1297, 16'h0000}, 2'd0, 2'd2);
    chk("R4 chain join1", 1'b1, 32'h0000_0293, 32'h12A, 2'd1, 1'b0, 1'b0);
    step();
    chk("R7 held after join", 1'b0, 0, 0, 0, 0, 1'b1);
    step();
    put(32'h130, {16'h4505, 16'h0000}, 2'd1, 2'd3);
    chk("R4 chain join2", 1'b1, 32'h0000_1297, 32'h12E, 2'd2, 1'b0, 1'b0);
    step();
    chk("R7 chain tail", 1'b1, 32'h0000_4505, 32'h132, 2'd3, 1'b1, 1'b1);
    step();
  endtask

  task automatic t_flush();
    redirect(32'h13A);
    put(32'h138, {16'h0293, 16'h0001}, 2'd0, 2'd1);
    chk("R6 pre-flush stall", 1'b0, 0, 0, 0, 0, 1'b1);
    step();
    redirect(32'h140);
    put(32'h140, 32'h00A0_0093, 2'd2, 2'd1);
    chk("R8 flushed no join", 1'b1, 32'h00A0_0093, 32'h140, 2'd2, 1'b0, 1'b1);
    step();
    in_valid = 1'b0;
    chk("R1 idle again", 1'b0, 0, 0, 0, 0, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_full();
    t_pair();
    t_backpressure();
    t_enter_c();
    t_enter_join();
    t_chain();
    t_flush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule